// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatch

This block is the control unit of a small 12-bit accumulator processor. It holds a read-only control store of 26 microwords, each 28 bits wide, and a 5-bit micro-address register. On every rising clock edge it fetches the microword at the current micro-address into an output register and presents its upper 23 bits to the datapath as individual control strobes. A strobe at 1 triggers its micro-operation and a strobe at 0 leaves it idle.

On the same edge it forms the next micro-address from the low 5 bits of the fetched word. Most values of that field are loaded as they are. Four reserved values instead start a multiway branch on bits of the instruction word: the destination addressing-mode bit, the opcode, the register-select bit, or the source addressing-mode bit. This lets a single microprogram decode every instruction: fetch, operand access, one ALU word per opcode, then write-back and return to fetch.

The instruction word is 12 bits wide with the opcode in bits 11:9. The datapath and main memory are not part of this block.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high, `uAddr`, `uWord` and `ctl` are all zero.
- R2: On each rising edge, `uWord` takes the store word at the previous `uAddr`, and `ctl` equals `uWord[27:5]`. Addresses 26 to 31 read as an all-zero word.
- R3: A next-address field outside 26..29 is loaded unchanged into `uAddr`.
- R4: Field 26 branches to 4 when `ir[6]` is 0 (register operand) and to 5 when it is 1 (indirect operand).
- R5: Field 27 branches to 16 plus the opcode `ir[11:9]`: DEC=000 to 16, MOV=001 to 17, ADD=010 to 18, SUB=011 to 19, OR=100 to 20, AND=101 to 21, INC=110 to 22. The unused opcode 111 goes to 23, whose word has no strobes and returns to 0.
- R6: Field 28 branches to 6 plus `ir[0]`, the register-select bit.
- R7: Field 29 branches to 8 plus `ir[3]`, the source addressing-mode bit.
- R8: Fetch: word 0 sets word bits 15 (PC onto bus) and 11 (load memory address) with next field 1. Word 1 reads memory and steps the PC. Word 2 sets bits 18 (memory data onto bus) and 10 (load instruction register) with next field 26.
- R9: Each opcode word 16..22 sets exactly one ALU strobe and has next field 24. The ALU strobes are bit 21 DEC, 20 MOV, 23 ADD, 24 SUB, 26 OR, 25 AND, 22 INC.
- R10: Word 24 sets bits 19 (accumulator onto bus) and 12 (load memory data) with next field 25. Word 25 sets only bit 6 (memory select with write) and returns to 0.
- R11: Register operand path: 4 goes to 28, and 6 or 7 goes to 27. Indirect path: 5 goes to 29, then 8 or 9, then 10, then 11, then 27.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| ir | input | 12 | Instruction register contents; opcode in bits 11:9 |
| ctl | output | 23 | Control strobes, `uWord[27:5]` |
| uAddr | output | 5 | Micro-address register (address of the next word to fetch) |
| uWord | output | 28 | Microword fetched on the last edge |

## Verification
Both `uAddr` and `uWord` change on a rising edge, one register after the address they depend on. After an edge, `uAddr` already holds the branch result built from the word fetched on that edge and from `ir` as it stood at that edge. A driver task changes `ir` 2 ns after a falling edge, at the point where the machine sits at micro-address 0. It then queues the expected micro-address for each of the following edges, together with the strobes expected where a known word has just been fetched. The monitor takes one item per falling edge, so each comparison falls half a period after the edge that produced the value. It also checks every observed step against the branch rule, using the current `ir`.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int WORD_W      = 28;
  localparam int ADDR_W      = 5;
  localparam int IR_W        = 12;
  localparam int OP_W        = 3;
  localparam int STORE_DEPTH = 26;
  localparam int CTL_W       = WORD_W - ADDR_W;

  // instruction bit positions used by the dispatch branches
  localparam int IR_MODE_BIT = 6;
  localparam int IR_SRC_BIT  = 3;
  localparam int IR_REG_BIT  = 0;

  // reserved next-address codes
  localparam int CODE_MODE = 26;
  localparam int CODE_OP   = 27;
  localparam int CODE_REG  = 28;
  localparam int CODE_SRC  = 29;

  // branch base addresses
  localparam int MODE_BASE = 4;
  localparam int REG_BASE  = 6;
  localparam int SRC_BASE  = 8;
  localparam int OP_BASE   = 16;

  // opcode values
  localparam int OP_DEC = 0;
  localparam int OP_MOV = 1;
  localparam int OP_ADD = 2;
  localparam int OP_SUB = 3;
  localparam int OP_OR  = 4;
  localparam int OP_AND = 5;
  localparam int OP_INC = 6;
  localparam int OP_BAD = 7;

  // control bit positions inside the microword
  localparam int B_LDPC   = 27;
  localparam int B_ORACC  = 26;
  localparam int B_ANDACC = 25;
  localparam int B_SUBACC = 24;
  localparam int B_ADDACC = 23;
  localparam int B_INCACC = 22;
  localparam int B_DECACC = 21;
  localparam int B_MOVACC = 20;
  localparam int B_ACCBUS = 19;
  localparam int B_MDRBUS = 18;
  localparam int B_R1BUS  = 17;
  localparam int B_R0BUS  = 16;
  localparam int B_PCBUS  = 15;
  localparam int B_LDD    = 14;
  localparam int B_LDC    = 13;
  localparam int B_LDMDR  = 12;
  localparam int B_LDMAR  = 11;
  localparam int B_LDIR   = 10;
  localparam int B_LDR1   = 9;
  localparam int B_LDR0   = 8;
  localparam int B_INCPC  = 7;
  localparam int B_MEMSEL = 6;
  localparam int B_MEMRD  = 5;

  // strobes from the control part to the datapath part
  typedef struct packed {
    logic selMode;
    logic selOp;
    logic selReg;
    logic selSrc;
  } seqSel_t;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int UW    = WORD_W,
  parameter int DEPTH = STORE_DEPTH
) (
  input  logic [AW-1:0] addr,
  output logic [UW-1:0] word
);

  function automatic logic [UW-1:0] cb(input int pos);
    return UW'(1) << pos;
  endfunction

  function automatic logic [UW-1:0] nx(input int target);
    return UW'(target);
  endfunction

  always_comb begin
    word = '0;
    if (int'(addr) < DEPTH) begin
      case (int'(addr))
        // fetch
        0:  word = cb(B_PCBUS) | cb(B_LDMAR) | nx(1);
        1:  word = cb(B_MEMSEL) | cb(B_MEMRD) | cb(B_INCPC) | nx(2);
        2:  word = cb(B_MDRBUS) | cb(B_LDIR) | nx(CODE_MODE);
        3:  word = nx(0);
        // destination operand mode
        4:  word = nx(CODE_REG);
        5:  word = nx(CODE_SRC);
        // register operand into D
        6:  word = cb(B_R0BUS) | cb(B_LDD) | nx(CODE_OP);
        7:  word = cb(B_R1BUS) | cb(B_LDD) | nx(CODE_OP);
        // indirect operand: address from register, read memory into D
        8:  word = cb(B_R0BUS) | cb(B_LDMAR) | nx(10);
        9:  word = cb(B_R1BUS) | cb(B_LDMAR) | nx(10);
        10: word = cb(B_MEMSEL) | cb(B_MEMRD) | nx(11);
        11: word = cb(B_MDRBUS) | cb(B_LDD) | nx(CODE_OP);
        // second operand loaders, reachable only by direct address
        12: word = cb(B_R0BUS) | cb(B_LDC) | nx(0);
        13: word = cb(B_R1BUS) | cb(B_LDC) | nx(0);
        14: word = cb(B_ACCBUS) | cb(B_LDR0) | nx(0);
        15: word = cb(B_ACCBUS) | cb(B_LDR1) | nx(0);
        // one ALU word per opcode
        OP_BASE + OP_DEC: word = cb(B_DECACC) | nx(24);
        OP_BASE + OP_MOV: word = cb(B_MOVACC) | nx(24);
        OP_BASE + OP_ADD: word = cb(B_ADDACC) | nx(24);
        OP_BASE + OP_SUB: word = cb(B_SUBACC) | nx(24);
        OP_BASE + OP_OR:  word = cb(B_ORACC)  | nx(24);
        OP_BASE + OP_AND: word = cb(B_ANDACC) | nx(24);
        OP_BASE + OP_INC: word = cb(B_INCACC) | nx(24);
        OP_BASE + OP_BAD: word = nx(0);
        // write-back
        24: word = cb(B_ACCBUS) | cb(B_LDMDR) | nx(25);
        25: word = cb(B_MEMSEL) | nx(0);
        default: word = '0;
      endcase
    end
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] nxField,
  output seqSel_t       sel
);

  always_comb begin
    sel = '0;
    case (int'(nxField))
      CODE_MODE: sel.selMode = 1'b1;
      CODE_OP:   sel.selOp   = 1'b1;
      CODE_REG:  sel.selReg  = 1'b1;
      CODE_SRC:  sel.selSrc  = 1'b1;
      default:   sel = '0;
    endcase
  end

endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int UW    = WORD_W,
  parameter int OPW   = OP_W,
  parameter int DEPTH = STORE_DEPTH,
  localparam int CW   = UW - AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] irOp,
  input  logic           irMode,
  input  logic           irSrc,
  input  logic           irReg,
  input  seqSel_t        sel,
  output logic [AW-1:0]  nxField,
  output logic [AW-1:0]  uAddr,
  output logic [UW-1:0]  uWord,
  output logic [CW-1:0]  ctl
);

  logic [UW-1:0] romWord;
  logic [AW-1:0] nextAddr;
  logic [AW-1:0] uAddrQ;
  logic [UW-1:0] uWordQ;

  useq_rom #(.AW(AW), .UW(UW), .DEPTH(DEPTH)) u_rom (
    .addr (uAddrQ),
    .word (romWord)
  );

  assign nxField = romWord[AW-1:0];

  always_comb begin
    if (sel.selMode)
      nextAddr = AW'(MODE_BASE) + AW'(irMode);
    else if (sel.selOp)
      nextAddr = AW'(OP_BASE) + AW'(irOp);
    else if (sel.selReg)
      nextAddr = AW'(REG_BASE) + AW'(irReg);
    else if (sel.selSrc)
      nextAddr = AW'(SRC_BASE) + AW'(irSrc);
    else
      nextAddr = nxField;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      uAddrQ <= '0;
      uWordQ <= '0;
    end else begin
      uAddrQ <= nextAddr;
      uWordQ <= romWord;
    end
  end

  assign uAddr = uAddrQ;
  assign uWord = uWordQ;
  assign ctl   = uWordQ[UW-1:AW];

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IR_W-1:0]   ir,
  output logic [CTL_W-1:0]  ctl,
  output logic [ADDR_W-1:0] uAddr,
  output logic [WORD_W-1:0] uWord
);

  seqSel_t           sel;
  logic [ADDR_W-1:0] nxField;
  logic              unusedIrBits;

  assign unusedIrBits = ^{ir[8:7], ir[5:4], ir[2:1]};

  useq_ctrl #(.AW(ADDR_W)) u_ctrl (
    .nxField (nxField),
    .sel     (sel)
  );

  useq_dpath #(
    .AW    (ADDR_W),
    .UW    (WORD_W),
    .OPW   (OP_W),
    .DEPTH (STORE_DEPTH)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .irOp    (ir[IR_W-1 -: OP_W]),
    .irMode  (ir[IR_MODE_BIT]),
    .irSrc   (ir[IR_SRC_BIT]),
    .irReg   (ir[IR_REG_BIT]),
    .sel     (sel),
    .nxField (nxField),
    .uAddr   (uAddr),
    .uWord   (uWord),
    .ctl     (ctl)
  );

endmodule

// File: rtl/useq_checker.sv
module useq_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] irOp,
  input logic       irMode,
  input logic       irSrc,
  input logic       irReg,
  input logic [6:0] ctlAlu,
  input logic [4:0] uAddr,
  input logic [4:0] uNext,
  input logic [1:0] uFetch
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |-> (uAddr == 5'd0 && uNext == 5'd0 && uFetch == 2'b00));

  a_r3_direct_load: assert property (@(posedge clk) disable iff (rst)
    (uNext < 5'd26 || uNext > 5'd29) |-> (uAddr == uNext));

  a_r4_mode_branch: assert property (@(posedge clk) disable iff (rst)
    (uNext == 5'd26) |-> (uAddr == {4'b0010, $past(irMode)}));

  a_r5_opcode_branch: assert property (@(posedge clk) disable iff (rst)
    (uNext == 5'd27) |-> (uAddr == {2'b10, $past(irOp)}));

  a_r6_reg_branch: assert property (@(posedge clk) disable iff (rst)
    (uNext == 5'd28) |-> (uAddr == {4'b0011, $past(irReg)}));

  a_r7_src_branch: assert property (@(posedge clk) disable iff (rst)
    (uNext == 5'd29) |-> (uAddr == {4'b0100, $past(irSrc)}));

  a_r8_fetch_word: assert property (@(posedge clk) disable iff (rst)
    (uAddr == 5'd0) |=> (uFetch == 2'b11 && uNext == 5'd1));

  a_r9_alu_single: assert property (@(posedge clk) disable iff (rst)
    (uAddr >= 5'd16 && uAddr <= 5'd22) |=> ($countones(ctlAlu) == 1 && uNext == 5'd24));

endmodule

bind useq_top useq_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .irOp   (ir[11:9]),
  .irMode (ir[6]),
  .irSrc  (ir[3]),
  .irReg  (ir[0]),
  .ctlAlu (ctl[21:15]),
  .uAddr  (uAddr),
  .uNext  (uWord[4:0]),
  .uFetch ({uWord[15], uWord[11]})
);

// File: tb/useq_top_tb.sv
module useq_top_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] ir;
  logic [22:0] ctl;
  logic [4:0]  uAddr;
  logic [27:0] uWord;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  useq_top u_dut (
    .clk   (clk),
    .rst   (rst),
    .ir    (ir),
    .ctl   (ctl),
    .uAddr (uAddr),
    .uWord (uWord)
  );

  typedef struct {
    logic [4:0]  addr;
    bit          chk;
    logic [22:0] ctlExp;
    string       tag;
  } item_t;

  item_t q[$];

  // strobe positions in ctl are word bit minus 5
  localparam logic [22:0] FETCH0_CTL = (23'd1 << 10) | (23'd1 << 6);
  localparam logic [22:0] FETCH2_CTL = (23'd1 << 13) | (23'd1 << 5);
  localparam logic [22:0] WB24_CTL   = (23'd1 << 14) | (23'd1 << 7);
  localparam logic [22:0] WB25_CTL   = (23'd1 << 1);

  function automatic logic [22:0] aluCtl(input logic [2:0] op);
    case (op)
      3'd0: return 23'd1 << 16;
      3'd1: return 23'd1 << 15;
      3'd2: return 23'd1 << 18;
      3'd3: return 23'd1 << 19;
      3'd4: return 23'd1 << 21;
      3'd5: return 23'd1 << 20;
      3'd6: return 23'd1 << 17;
      default: return 23'd0;
    endcase
  endfunction

  function automatic logic [4:0] refNext(input logic [4:0] f, input logic [11:0] i);
    case (f)
      5'd26:   return {4'b0010, i[6]};
      5'd27:   return {2'b10, i[11:9]};
      5'd28:   return {4'b0011, i[0]};
      5'd29:   return {4'b0100, i[3]};
      default: return f;
    endcase
  endfunction

  function automatic string ruleTag(input logic [4:0] f);
    case (f)
      5'd26:   return "R4";
      5'd27:   return "R5";
      5'd28:   return "R6";
      5'd29:   return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [11:0] mkIr(input logic [2:0] op, input logic m,
                                       input logic s, input logic r, input logic [5:0] fill);
    return {op, fill[5:4], m, fill[3:2], s, fill[1:0], r};
  endfunction

  task automatic push(input logic [4:0] a, input bit c, input logic [22:0] k, input string t);
    item_t it;
    it.addr = a; it.chk = c; it.ctlExp = k; it.tag = t;
    q.push_back(it);
  endtask

  // driver: start one instruction when the machine is back at address 0
  task automatic runInstr(input logic [11:0] i);
    logic [2:0] op;
    op = i[11:9];
    wait (q.size() == 0);
    #2;
    ir = i;
    push(5'd1, 1'b1, FETCH0_CTL, "R8 fetch word 0");
    push(5'd2, 1'b0, 23'd0, "R11 fetch step");
    if (!i[6]) begin
      push(5'd4, 1'b1, FETCH2_CTL, "R4 mode branch register / R8 word 2");
      push(5'd6 + {4'd0, i[0]}, 1'b0, 23'd0, "R6 register select");
    end else begin
      push(5'd5, 1'b1, FETCH2_CTL, "R4 mode branch indirect / R8 word 2");
      push(5'd8 + {4'd0, i[3]}, 1'b0, 23'd0, "R7 source mode");
      push(5'd10, 1'b0, 23'd0, "R11 indirect address");
      push(5'd11, 1'b0, 23'd0, "R11 indirect read");
    end
    push(5'd16 + {2'd0, op}, 1'b0, 23'd0, "R5 opcode branch");
    if (op != 3'd7) begin
      push(5'd24, 1'b1, aluCtl(op), "R9 ALU word");
      push(5'd25, 1'b1, WB24_CTL, "R10 write-back word 24");
      push(5'd0, 1'b1, WB25_CTL, "R10 write-back word 25");
    end else begin
      push(5'd0, 1'b1, 23'd0, "R5 unused opcode word");
    end
  endtask

  // monitor
  always @(negedge clk) begin
    item_t it;
    if (!rst && q.size() > 0) begin
      it = q.pop_front();
      nTests++;
      if (uAddr !== it.addr) begin
        nFail++;
        $display("FAIL %s: uAddr actual=%0d expected=%0d", it.tag, uAddr, it.addr);
      end
      if (it.chk) begin
        nTests++;
        if (ctl !== it.ctlExp) begin
          nFail++;
          $display("FAIL %s: ctl actual=%h expected=%h", it.tag, ctl, it.ctlExp);
        end
      end
      nTests++;
      if (ctl !== uWord[27:5] || uAddr !== refNext(uWord[4:0], ir)) begin
        nFail++;
        $display("FAIL R2/%s rule: uAddr actual=%0d expected=%0d ctl actual=%h expected=%h",
                 ruleTag(uWord[4:0]), uAddr, refNext(uWord[4:0], ir), ctl, uWord[27:5]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R2 watchdog: actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ir  = 12'd0;
    repeat (3) @(negedge clk);
    nTests++;
    if (uAddr !== 5'd0 || uWord !== 28'd0 || ctl !== 23'd0) begin
      nFail++;
      $display("FAIL R1: uAddr=%0d uWord=%h ctl=%h expected all zero", uAddr, uWord, ctl);
    end
    rst = 1'b0;

    runInstr(mkIr(3'd2, 1'b0, 1'b0, 1'b1, 6'b000000)); // ADD register R1
    runInstr(mkIr(3'd3, 1'b1, 1'b0, 1'b1, 6'b111111)); // SUB indirect, src mode 0
    runInstr(mkIr(3'd4, 1'b1, 1'b1, 1'b0, 6'b101010)); // OR indirect, src mode 1
    runInstr(mkIr(3'd5, 1'b0, 1'b1, 1'b0, 6'b010101)); // AND register R0
    runInstr(mkIr(3'd6, 1'b0, 1'b0, 1'b1, 6'b111111)); // INC
    runInstr(mkIr(3'd0, 1'b1, 1'b1, 1'b1, 6'b000000)); // DEC
    runInstr(mkIr(3'd1, 1'b0, 1'b1, 1'b0, 6'b110011)); // MOV
    runInstr(mkIr(3'd7, 1'b0, 1'b0, 1'b1, 6'b000000)); // unused opcode, register
    runInstr(mkIr(3'd7, 1'b1, 1'b1, 1'b0, 6'b111111)); // unused opcode, indirect
    runInstr(mkIr(3'd2, 1'b0, 1'b1, 1'b0, 6'b000000)); // ADD register R0

    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule